// File: doc/BRIEF.md
# Prime-factor FFT input reorder buffer

This block turns a stream of 1008-sample frames, delivered in natural order, into the index order that a three-dimensional prime factor FFT with sizes 7, 9 and 16 needs in its first stage. No twiddle multiplies sit between the stages of such a transform, but its input must be scrambled by a modular index map. This block performs that scramble at full rate, eight complex samples per clock, ahead of a bank of 7-point DFT engines.

Two 128-bit input lanes move together under one valid/ready handshake. Each beat carries eight consecutive samples. A frame is written into one half of a ping-pong store, and the other half is read out at the same time. Read addresses come from a permutation table built at elaboration. The output is cut into 7-point transforms: even-numbered transforms go on output stream 0 and odd-numbered ones on stream 1. The two output streams move together under one valid/ready handshake. When both halves hold unread frames, input is held off.

Top module: `pfa_in_perm`

## Requirements
- R1: After reset, out_valid is 0 and in_ready is 1.
- R2: With in_valid and out_ready held high, the first output beat is valid exactly 127 cycles after the cycle in which the first input beat is accepted.
- R3: A sample is 32 bits (I in bits 31:16, Q in bits 15:0) and is moved unchanged. Input beat c of a frame carries sample 8c+l on in_data0 lane l and sample 8c+4+l on in_data1 lane l, for l = 0..3. Lane l occupies bits [32l+31:32l]. Cube position (n1,n2,n3), with n1<7, n2<9 and n3<16, takes input sample (144*n1 + 112*n2 + 63*n3) mod 1008.
- R4: Transform t (0..143) consists of n1 = 0..6 at n2 = t mod 9 and n3 = t div 9, and goes entirely on stream t mod 2. Each stream packs its transforms' points in order, four per beat, starting at lane 0. A frame is 126 beats per stream. For example, stream 1 beat 1 lane 3 carries input sample 336.
- R5: With in_valid and out_ready held high, frames stream back to back and in_ready never drops.
- R6: When two unread frames are stored, in_ready is 0. No more than two frames plus the beat in the output register are accepted ahead of output.
- R7: While out_valid is 1 and out_ready is 0, out_valid and both output data buses hold their values.
- R8: Input data presented while in_ready is 0 has no effect on any output frame.
- R9: Idle cycles on in_valid or out_ready at any point do not change frame content or order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input beat present on both lanes |
| in_ready | output | 1 | Input beat accepted this cycle if valid |
| in_data0 | input | 128 | Four samples, lower half of the beat |
| in_data1 | input | 128 | Four samples, upper half of the beat |
| out_valid | output | 1 | Output beat present on both streams |
| out_ready | input | 1 | Sink takes both output streams |
| out_data0 | output | 128 | Stream 0, even transforms |
| out_data1 | output | 128 | Stream 1, odd transforms |

## Verification
The hardest condition to reach is the one where both halves of the store are full. The input has to be refused while the output register holds a stalled beat. The bench gets there by holding out_ready low while it keeps offering beats. It feeds two whole frames and then presents marked garbage while in_ready is low. It then releases the sink and checks that both stored frames come out intact and that the garbage never appears. Irregular valid and ready patterns then exercise the bank swap at cycles other than the clean streaming ones.

// File: rtl/pfa_in_perm.sv
module pfa_in_perm #(
  parameter int N1    = 7,
  parameter int N2    = 9,
  parameter int N3    = 16,
  parameter int LANES = 4,
  parameter int SW    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [LANES*SW-1:0] in_data0,
  input  logic [LANES*SW-1:0] in_data1,
  output logic                out_valid,
  input  logic                out_ready,
  output logic [LANES*SW-1:0] out_data0,
  output logic [LANES*SW-1:0] out_data1
);
  localparam int N     = N1 * N2 * N3;
  localparam int SPC   = 2 * LANES;
  localparam int BEATS = N / SPC;
  localparam int AW    = $clog2(N);
  localparam int CW    = $clog2(BEATS);

  function automatic int pfa_addr(int pos);
    int c, s, l, j, k, p, t;
    c = pos / SPC;
    s = (pos / LANES) % 2;
    l = pos % LANES;
    j = c * LANES + l;
    k = j / N1;
    p = j % N1;
    t = 2 * k + s;
    return ((N / N1) * p + (N / N2) * (t % N2) + (N / N3) * (t / N2)) % N;
  endfunction

  logic [SW-1:0] mem [2][N];
  logic [AW-1:0] perm [N];
  logic [CW-1:0] wc, rc;
  logic          wb, rb;
  logic [1:0]    full;
  logic          acc, rd_go;

  for (genvar g = 0; g < N; g++) begin : g_tbl
    assign perm[g] = AW'(pfa_addr(g));
  end

  assign in_ready = !full[wb];
  assign acc      = in_valid && in_ready;
  assign rd_go    = full[rb] && (!out_valid || out_ready);

  always_ff @(posedge clk) begin
    if (acc) begin
      for (int l = 0; l < LANES; l++) begin
        mem[wb][AW'(wc) * AW'(SPC) + AW'(l)]         <= in_data0[l*SW +: SW];
        mem[wb][AW'(wc) * AW'(SPC) + AW'(LANES + l)] <= in_data1[l*SW +: SW];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rd_go) begin
      for (int l = 0; l < LANES; l++) begin
        out_data0[l*SW +: SW] <= mem[rb][perm[AW'(rc) * AW'(SPC) + AW'(l)]];
        out_data1[l*SW +: SW] <= mem[rb][perm[AW'(rc) * AW'(SPC) + AW'(LANES + l)]];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wc        <= '0;
      rc        <= '0;
      wb        <= 1'b0;
      rb        <= 1'b0;
      full      <= 2'b00;
      out_valid <= 1'b0;
    end else begin
      if (acc) begin
        if (wc == CW'(BEATS - 1)) begin
          wc       <= '0;
          wb       <= !wb;
          full[wb] <= 1'b1;
        end else begin
          wc <= wc + 1'b1;
        end
      end
      if (rd_go) begin
        out_valid <= 1'b1;
        if (rc == CW'(BEATS - 1)) begin
          rc       <= '0;
          rb       <= !rb;
          full[rb] <= 1'b0;
        end else begin
          rc <= rc + 1'b1;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pfa_in_perm_chk.sv
module pfa_in_perm_chk #(
  parameter int N1    = 7,
  parameter int N2    = 9,
  parameter int N3    = 16,
  parameter int LANES = 4,
  parameter int SW    = 32
) (
  input logic                clk,
  input logic                rst_n,
  input logic                in_valid,
  input logic                in_ready,
  input logic                out_valid,
  input logic                out_ready,
  input logic [LANES*SW-1:0] out_data0,
  input logic [LANES*SW-1:0] out_data1
);
  localparam int BEATS = (N1 * N2 * N3) / (2 * LANES);
  localparam int LIM   = 2 * BEATS + 1;

  logic [15:0] cnt;
  logic        acc, emit;
  assign acc  = in_valid && in_ready;
  assign emit = out_valid && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 16'(acc) - 16'(emit);
  end

  a_r7_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data0) && $stable(out_data1));

  a_r6_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> cnt < 16'(LIM));

  a_r8_valid_has_data: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> cnt != 16'd0);

  a_r5_ready_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
    cnt == 16'd0 |-> in_ready);
endmodule

bind pfa_in_perm pfa_in_perm_chk #(
  .N1(N1), .N2(N2), .N3(N3), .LANES(LANES), .SW(SW)
) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready),
  .out_data0(out_data0), .out_data1(out_data1)
);

// File: tb/tb_pfa_in_perm.sv
module tb_pfa_in_perm;
  localparam int N = 1008;
  localparam int BEATS = 126;

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, out_ready = 0;
  logic [127:0] in_data0 = '0, in_data1 = '0;
  logic in_ready, out_valid;
  logic [127:0] out_data0, out_data1;

  pfa_in_perm dut (.*);

  always #2.5 clk = ~clk;

  int total = 0, bad = 0;
  int exp_addr [2][N/2];
  int fin = 0, ib = 0, fin_target = 0;
  int fout = 0, ob = 0, fbad = 0;
  int step_no = 0, first_in = -1, first_out = -1, stalls = 0, accepted = 0;
  string tag = "R3";

  function automatic logic [31:0] samp(int f, int idx);
    return {6'(f), 10'(idx), 16'(idx * 97 + f * 13)};
  endfunction

  task automatic check(string r, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic consume();
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 4; l++) begin
        logic [31:0] a, e;
        a = s == 0 ? out_data0[l*32 +: 32] : out_data1[l*32 +: 32];
        e = samp(fout, exp_addr[s][4*ob + l]);
        if (a !== e) begin
          if (fbad == 0) $display("mismatch frame %0d beat %0d s%0d l%0d: %h vs %h", fout, ob, s, l, a, e);
          fbad++;
        end
      end
    if (fout == 0 && ob == 0) check("R4", out_data0[31:0], samp(0, 0));
    if (fout == 0 && ob == 1) check("R4", out_data1[127:96], samp(0, 336));
    if (ob == BEATS - 1) begin
      check(tag, 32'(fbad), 32'd0);
      fbad = 0; ob = 0; fout++;
    end else ob++;
  endtask

  task automatic step(logic v, logic r);
    @(negedge clk);
    out_ready = r;
    if (v && fin < fin_target) begin
      in_valid = 1;
      if (!in_ready) begin
        in_data0 = {4{32'hDEAD_0BAD}};
        in_data1 = {4{32'hDEAD_0BAD}};
      end else
        for (int l = 0; l < 4; l++) begin
          in_data0[l*32 +: 32] = samp(fin, 8*ib + l);
          in_data1[l*32 +: 32] = samp(fin, 8*ib + 4 + l);
        end
    end else begin
      in_valid = 0;
      in_data0 = {4{32'h0BAD_F00D}};
      in_data1 = {4{32'h0BAD_F00D}};
    end
    #1;
    if (in_valid && !in_ready) stalls++;
    if (in_valid && in_ready) begin
      if (first_in < 0) first_in = step_no;
      accepted++;
      if (ib == BEATS - 1) begin ib = 0; fin++; end else ib++;
    end
    if (out_valid && first_out < 0) first_out = step_no;
    if (out_valid && out_ready) consume();
    step_no++;
  endtask

  task automatic drain();
    while (fout < fin) step(0, 1);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", 32'(out_valid), 32'd0);
    check("R1", 32'(in_ready), 32'd1);
  endtask

  task automatic t_stream();
    tag = "R3";
    fin_target = fin + 3;
    stalls = 0;
    while (fin < fin_target) step(1, 1);
    drain();
    check("R2", 32'(first_out - first_in), 32'd127);
    check("R5", 32'(stalls), 32'd0);
  endtask

  task automatic t_full();
    logic [127:0] h0, h1;
    tag = "R8";
    fin_target = fin + 3;
    accepted = 0;
    for (int i = 0; i < 300; i++) step(1, 0);
    check("R6", 32'(accepted), 32'(2 * BEATS));
    check("R6", 32'(in_ready), 32'd0);
    h0 = out_data0; h1 = out_data1;
    for (int i = 0; i < 20; i++) step(1, 0);
    check("R7", 32'(out_valid), 32'd1);
    check("R7", h0[31:0] ^ out_data0[31:0] | h1[127:96] ^ out_data1[127:96], 32'd0);
    check("R7", 32'(h0 == out_data0 && h1 == out_data1), 32'd1);
    while (fin < fin_target) step(1, 1);
    drain();
  endtask

  task automatic t_gaps();
    tag = "R9";
    fin_target = fin + 3;
    for (int i = 0; fin < fin_target; i++) step(i % 3 != 0, i % 5 != 1);
    for (int i = 0; fout < fin; i++) step(0, i % 4 != 2);
  endtask

  initial begin
    int cnt [2];
    cnt[0] = 0; cnt[1] = 0;
    for (int t = 0; t < N / 7; t++)
      for (int p = 0; p < 7; p++) begin
        exp_addr[t % 2][cnt[t % 2]] = (144 * p + 112 * (t % 9) + 63 * (t / 9)) % N;
        cnt[t % 2]++;
      end
    t_reset();
    t_stream();
    t_full();
    t_gaps();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(200000 * 5);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule